// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block controls the sleep state of a small processor core and the core's return to execution when an external interrupt arrives. While the core runs, the block produces the four instruction-cycle phases Q1..Q4 in a rotating one-hot pattern, one phase per oscillator clock. A sleep request from the instruction decoder is honoured at the end of a Q4. After that the phases stop and the core's run signal drops.

A rising edge on the interrupt pin is synchronized to the oscillator clock and sets a sticky interrupt flag. While the core sleeps, a set flag wakes it. The crystal-type oscillator modes first wait out an oscillator start-up period of 1024 clocks. The other modes resume at once. Execution always restarts at a Q1 with the instruction that was already prefetched when sleep was entered.

The global interrupt enable is sampled at wake-up and selects what happens next. When it is set, two dummy cycles follow the prefetched instruction. During the first of them, the block commands a program-counter redirect to the interrupt vector. When it is clear, execution simply continues in line.

Top module: `slumber_wake_seq`

## Requirements
- R1: After reset, core_run is 1, int_flag is 0, dummy_cyc and pc_redirect are 0, and phase_q is 4'b0001 (bit 0 = Q1, bit 1 = Q2, bit 2 = Q3, bit 3 = Q4). While core_run is 1, phase_q moves one bit up on every clock, wrapping from Q4 to Q1.
- R2: sleep_req is sampled only in normal execution, at the clock edge that ends a Q4. One clock later, core_run is 0 and phase_q is 4'b0000, and both stay so until wake-up.
- R3: A rising edge of int_pin sets int_flag at the third clock edge after the pin changes. This happens whether the core is running or asleep. A pin that stays high sets the flag no further, and waking the core while it runs causes no dummy cycle.
- R4: int_flag stays set until int_flag_clr is sampled high. When a new edge and a clear arrive on the same clock, the set wins. Vectoring does not clear the flag.
- R5: With osc_mode 0, 1 or 2 (crystal-type modes), core_run rises 1025 clocks after int_flag rises in sleep. The start-up count restarts from zero on every sleep.
- R6: With osc_mode 3 to 7 (clocked, internal and RC modes), the start-up wait is bypassed and core_run rises one clock after int_flag rises in sleep.
- R7: Execution resumes at Q1 (phase_q = 4'b0001), and the first resumed cycle is a normal cycle (dummy_cyc = 0) that completes the prefetched instruction.
- R8: If gie is 1 at wake-up, the two cycles after the first resumed cycle have dummy_cyc = 1. pc_redirect is 1 only during the first of them, with vec_addr = 13'h0004. Normal cycles follow.
- R9: If gie is 0 at wake-up, no dummy cycle and no redirect occur after wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_mode | input | 3 | Oscillator mode: 0..2 crystal-type, 3..7 no start-up wait |
| sleep_req | input | 1 | Sleep instruction executing (decoder) |
| int_pin | input | 1 | Asynchronous external interrupt pin, rising-edge active |
| int_flag_clr | input | 1 | Software clear of the interrupt flag |
| gie | input | 1 | Global interrupt enable |
| core_run | output | 1 | Core clocks run (1) or are held (0) |
| int_flag | output | 1 | Sticky external interrupt flag |
| phase_q | output | 4 | One-hot instruction-cycle phase Q1..Q4 |
| dummy_cyc | output | 1 | Current instruction cycle is a dummy cycle |
| pc_redirect | output | 1 | Load program counter with vec_addr |
| vec_addr | output | 13 | Interrupt vector target |

## Verification
A wrong state register or start-up count shows up as a shifted core_run rise, which the wake latency measured in clocks exposes to the exact cycle: 4 clocks from the pin change in bypass modes and 1028 in crystal modes. A wrong latched enable or sequencing state appears within the first three instruction cycles after resume, as a missing, extra or displaced dummy or redirect cycle. A broken flag register is visible within three clocks of a pin edge or a clear.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_WARM,
    ST_EXEC,
    ST_DUM1,
    ST_DUM2
  } wake_st_t;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned NUM_XTAL_MODES = 3;

  function automatic logic needs_warmup(input logic [MODE_W-1:0] mode);
    return mode < MODE_W'(NUM_XTAL_MODES);
  endfunction

  function automatic logic is_running(input wake_st_t st);
    return (st != ST_SLEEP) && (st != ST_WARM);
  endfunction
endpackage

// File: rtl/wake_phase_gen.sv
module wake_phase_gen #(
  parameter int unsigned NPH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_nxt,
  input  logic           restart,
  output logic [NPH-1:0] phase_q
);
  localparam logic [NPH-1:0] FIRST = NPH'(1);

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= FIRST;
    else if (!run_nxt)
      phase_q <= '0;
    else if (restart)
      phase_q <= FIRST;
    else
      phase_q <= {phase_q[NPH-2:0], phase_q[NPH-1]};
  end
endmodule

// File: rtl/wake_edge_flag.sv
module wake_edge_flag #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic clr,
  output logic flag
);
  logic [SYNC-1:0] sync_r;
  logic            prev_r;
  logic            edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r <= '0;
      prev_r <= 1'b0;
    end else begin
      sync_r <= {sync_r[SYNC-2:0], pin};
      prev_r <= sync_r[SYNC-1];
    end
  end

  assign edge_seen = sync_r[SYNC-1] & ~prev_r;

  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (edge_seen)
      flag <= 1'b1;
    else if (clr)
      flag <= 1'b0;
  end
endmodule

// File: rtl/wake_startup_cnt.sv
module wake_startup_cnt #(
  parameter int unsigned COUNT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic done
);
  localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] cnt_r;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_r <= '0;
    else if (en && cnt_r != LAST)
      cnt_r <= cnt_r + 1'b1;
  end

  assign done = en && (cnt_r == LAST);
endmodule

// File: rtl/slumber_wake_seq.sv
module slumber_wake_seq
  import wake_pkg::*;
#(
  parameter int unsigned START_CYCLES = 1024,
  parameter int unsigned PC_W = 13,
  parameter logic [PC_W-1:0] VEC = 13'h0004,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        osc_mode,
  input  logic              sleep_req,
  input  logic              int_pin,
  input  logic              int_flag_clr,
  input  logic              gie,
  output logic              core_run,
  output logic              int_flag,
  output logic [3:0]        phase_q,
  output logic              dummy_cyc,
  output logic              pc_redirect,
  output logic [PC_W-1:0]   vec_addr
);
  localparam int unsigned NPH = 4;

  wake_st_t state_r, state_nxt;
  logic     gie_lat;
  logic     warm_done;
  logic     end_of_cycle;

  assign end_of_cycle = phase_q[NPH-1];

  wake_edge_flag #(.SYNC(SYNC_STAGES)) u_flag (
    .clk  (clk),
    .rst  (rst),
    .pin  (int_pin),
    .clr  (int_flag_clr),
    .flag (int_flag)
  );

  wake_startup_cnt #(.COUNT(START_CYCLES)) u_warm (
    .clk   (clk),
    .rst   (rst),
    .clear (state_r != ST_WARM),
    .en    (state_r == ST_WARM),
    .done  (warm_done)
  );

  wake_phase_gen #(.NPH(NPH)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .run_nxt (is_running(state_nxt)),
    .restart (is_running(state_nxt) && !is_running(state_r)),
    .phase_q (phase_q)
  );

  always_comb begin
    state_nxt = state_r;
    unique case (state_r)
      ST_RUN:   if (end_of_cycle && sleep_req) state_nxt = ST_SLEEP;
      ST_SLEEP: if (int_flag) begin
                  if (needs_warmup(osc_mode)) state_nxt = ST_WARM;
                  else                        state_nxt = gie ? ST_EXEC : ST_RUN;
                end
      ST_WARM:  if (warm_done) state_nxt = gie_lat ? ST_EXEC : ST_RUN;
      ST_EXEC:  if (end_of_cycle) state_nxt = ST_DUM1;
      ST_DUM1:  if (end_of_cycle) state_nxt = ST_DUM2;
      ST_DUM2:  if (end_of_cycle) state_nxt = ST_RUN;
      default:  state_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r     <= ST_RUN;
      gie_lat     <= 1'b0;
      core_run    <= 1'b1;
      dummy_cyc   <= 1'b0;
      pc_redirect <= 1'b0;
    end else begin
      state_r     <= state_nxt;
      if (state_r == ST_SLEEP && int_flag)
        gie_lat <= gie;
      core_run    <= is_running(state_nxt);
      dummy_cyc   <= (state_nxt == ST_DUM1) || (state_nxt == ST_DUM2);
      pc_redirect <= (state_nxt == ST_DUM1);
    end
  end

  assign vec_addr = VEC;
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int unsigned PC_W = 13,
  parameter logic [PC_W-1:0] VEC = 13'h0004
) (
  input logic            clk,
  input logic            rst,
  input logic            sleep_req,
  input logic            int_flag_clr,
  input logic            core_run,
  input logic            int_flag,
  input logic [3:0]      phase_q,
  input logic            dummy_cyc,
  input logic            pc_redirect,
  input logic [PC_W-1:0] vec_addr
);
  a_r1_rotate: assert property (@(posedge clk) disable iff (rst)
    (core_run && phase_q[0]) |=> (core_run && phase_q[1]));

  a_r1_onehot_run: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_q) == (core_run ? 1 : 0));

  a_r2_sleep_at_q4: assert property (@(posedge clk) disable iff (rst)
    $fell(core_run) |-> $past(phase_q[3] && sleep_req));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (int_flag && !int_flag_clr) |=> int_flag);

  a_r7_resume_q1: assert property (@(posedge clk) disable iff (rst)
    $rose(core_run) |-> (phase_q == 4'b0001 && !dummy_cyc));

  a_r8_redirect_target: assert property (@(posedge clk) disable iff (rst)
    pc_redirect |-> (dummy_cyc && vec_addr == VEC));

  a_r8_second_dummy: assert property (@(posedge clk) disable iff (rst)
    $fell(pc_redirect) |-> dummy_cyc);
endmodule

bind slumber_wake_seq wake_seq_chk #(.PC_W(PC_W), .VEC(VEC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_req    (sleep_req),
  .int_flag_clr (int_flag_clr),
  .core_run     (core_run),
  .int_flag     (int_flag),
  .phase_q      (phase_q),
  .dummy_cyc    (dummy_cyc),
  .pc_redirect  (pc_redirect),
  .vec_addr     (vec_addr)
);

// File: tb/tb_slumber_wake_seq.sv
`timescale 1ns/1ps
module tb_slumber_wake_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  osc_mode = 3'd3;
  logic        sleep_req = 1'b0;
  logic        int_pin = 1'b0;
  logic        int_flag_clr = 1'b0;
  logic        gie = 1'b0;
  logic        core_run, int_flag, dummy_cyc, pc_redirect;
  logic [3:0]  phase_q;
  logic [12:0] vec_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int exp_q[$];

  localparam int K_NORM = 0;
  localparam int K_D1 = 1;
  localparam int K_D2 = 2;

  always #4 clk = ~clk;

  slumber_wake_seq dut (
    .clk(clk), .rst(rst), .osc_mode(osc_mode), .sleep_req(sleep_req),
    .int_pin(int_pin), .int_flag_clr(int_flag_clr), .gie(gie),
    .core_run(core_run), .int_flag(int_flag), .phase_q(phase_q),
    .dummy_cyc(dummy_cyc), .pc_redirect(pc_redirect), .vec_addr(vec_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: classifies each resumed instruction cycle at its Q1
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0 && core_run && phase_q == 4'b0001) begin
      int kind;
      int e;
      kind = !dummy_cyc ? K_NORM : (pc_redirect ? K_D1 : K_D2);
      e = exp_q.pop_front();
      check("R7/R8/R9 cycle kind", kind, e);
      if (pc_redirect) check("R8 vector address", int'(vec_addr), 4);
    end
  end

  task automatic go_sleep();
    @(negedge clk);
    sleep_req = 1'b1;
    while (core_run) @(negedge clk);
    sleep_req = 1'b0;
    check("R2 phase held in sleep", int'(phase_q), 0);
    repeat (5) @(negedge clk);
    check("R2 still asleep", int'(core_run), 0);
  endtask

  task automatic wake(input logic [2:0] mode, input logic en, input int lat);
    int n;
    osc_mode = mode;
    gie = en;
    if (en) begin
      exp_q.push_back(K_NORM); exp_q.push_back(K_D1);
      exp_q.push_back(K_D2);   exp_q.push_back(K_NORM);
    end else begin
      exp_q.push_back(K_NORM); exp_q.push_back(K_NORM);
      exp_q.push_back(K_NORM);
    end
    int_pin = 1'b1;
    n = 0;
    while (!core_run && n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    check(mode < 3 ? "R5 crystal wake latency" : "R6 bypass wake latency", n, lat);
    check("R7 resume at Q1", int'(phase_q), 1);
    while (exp_q.size() > 0) @(negedge clk);
    check("R4 flag kept after wake", int'(int_flag), 1);
    int_flag_clr = 1'b1;
    @(negedge clk);
    int_flag_clr = 1'b0;
    int_pin = 1'b0;
    check("R4 flag cleared by software", int'(int_flag), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state and rotation
    check("R1 reset core_run", int'(core_run), 1);
    check("R1 reset int_flag", int'(int_flag), 0);
    check("R1 reset dummy", int'(dummy_cyc), 0);
    check("R1 reset redirect", int'(pc_redirect), 0);
    for (int i = 0; i < 8; i++) begin
      check("R1 phase rotation", int'(phase_q), 1 << (i % 4));
      @(negedge clk);
    end

    // R3 edge while running, no vectoring
    int_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R3 flag not yet set", int'(int_flag), 0);
    @(negedge clk);
    check("R3 flag set third edge", int'(int_flag), 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R3 no dummy while running", int'(dummy_cyc), 0);
    end
    int_flag_clr = 1'b1;
    @(negedge clk);
    int_flag_clr = 1'b0;
    check("R4 clear", int'(int_flag), 0);
    repeat (6) @(negedge clk);
    check("R3 held level sets nothing", int'(int_flag), 0);
    int_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R4 set wins over clear
    int_flag_clr = 1'b1;
    int_pin = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R4 set beats clear", int'(int_flag), 1);
    @(negedge clk);
    int_flag_clr = 1'b0;
    int_pin = 1'b0;
    check("R4 cleared after edge", int'(int_flag), 0);
    repeat (4) @(negedge clk);

    // wake scenarios
    go_sleep(); wake(3'd3, 1'b1, 4);     // R6 + R8
    go_sleep(); wake(3'd1, 1'b0, 1028);  // R5 + R9
    go_sleep(); wake(3'd2, 1'b1, 1028);  // R5 restart + R8
    go_sleep(); wake(3'd6, 1'b0, 4);     // R6 + R9
    go_sleep(); wake(3'd0, 1'b1, 1028);  // R5 LP mode

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule